// File: doc/BRIEF.md
# Two-Stage Storage-Card Clock Divider

This block turns a fast reference clock into two single-cycle clock-enable streams for a storage-card host controller. A first stage divides by a power of two from 1 to 16 and yields the host-side enable. A second stage counts those host ticks and divides again by 2 or 4 to yield the card enable, so the card rate is the reference rate divided by a ratio between 2 and 64. Logic downstream qualifies its flops with these enables rather than running off separately generated clocks.

One 10-bit configuration word sets both stages and holds an independent stop bit for each output. Writes to the divider fields are held back until the card period in progress has finished, so a change of ratio never shortens or splits a period. The stop bits take effect at once. A status output reports whether the clock counts as running, which is the case only when both stop bits are clear.

Top module: `cardclk_div`

## Requirements
- R1: After reset, `hostClkEn` and `cardClkEn` are low, `clkRunning` is low and `rdData` reads 0x301 (both stops set, source code 0, final code 1).
- R2: A write stores bits 9, 8 and 4:0 of `wrData`; `rdData` returns them unchanged, including reserved codes, and bits 7:5 read as 0.
- R3: The source-divider code in bits 4:2 selects a host-enable period of 1, 2, 4, 8 or 16 reference cycles for codes 0, 1, 2, 3 and 4.
- R4: The final-divider code in bits 1:0 makes the card-enable period 2 host periods for code 0 and 4 host periods for code 1; every card pulse falls in a cycle that also carries a host tick.
- R5: Source codes 5 to 7 behave as code 4 (divide by 16) and final codes 2 and 3 behave as code 1 (divide by 4).
- R6: While bit 8 is 1, `cardClkEn` stays low and `hostClkEn` keeps running.
- R7: While bit 9 is 1, `hostClkEn` stays low and `cardClkEn` keeps running.
- R8: While the source code in effect is 2 or higher, `hostClkEn` stays low regardless of bit 9.
- R9: `clkRunning` is 1 exactly when bits 9 and 8 are both 0.
- R10: A change to bits 4:0 takes effect at the end of the current card period: the period in progress completes at its old length, and the following one has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the configuration word |
| wrData | input | 10 | Configuration word to store |
| rdData | output | 10 | Stored configuration word |
| hostClkEn | output | 1 | Host-side enable, one cycle per pre-divider period |
| cardClkEn | output | 1 | Card enable, one cycle per total period |
| clkRunning | output | 1 | High when neither stop bit is set |

## Verification
The bench measures both enable periods for all ten legal field combinations, so a swapped or off-by-one decode shows up as a wrong cycle count. It writes reserved codes to catch a design that wraps them to a small ratio instead of clamping. It rewrites the fields part-way through a divide-by-64 period; a design that applied the change at once would emit a card pulse far earlier than 64 cycles. It sets each stop bit alone and counts pulses on both outputs, which catches stop bits that are swapped or that gate both outputs.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int REG_W          = 10;
  localparam int HOST_STOP_POS  = 9;
  localparam int CARD_STOP_POS  = 8;
  localparam int SRC_LSB        = 2;
  localparam int SRC_W          = 3;
  localparam int FIN_LSB        = 0;
  localparam int FIN_W          = 2;
  localparam int MAX_SRC_CODE   = 4;
  localparam int HOST_OFF_CODE  = 2;
  localparam int PRE_W          = MAX_SRC_CODE;
  localparam logic [REG_W-1:0] RESET_WORD = 10'h301;

  // Strobes and selects handed from control to datapath
  typedef struct packed {
    logic [SRC_W-1:0] srcCode;
    logic             finLong;
    logic             holdHost;
    logic             holdCard;
  } dpCtrl_t;

  function automatic logic [REG_W-1:0] writeMask();
    logic [REG_W-1:0] m;
    m = '0;
    m[HOST_STOP_POS] = 1'b1;
    m[CARD_STOP_POS] = 1'b1;
    for (int i = 0; i < SRC_W; i++) m[SRC_LSB + i] = 1'b1;
    for (int i = 0; i < FIN_W; i++) m[FIN_LSB + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             cardTick,
  output logic [REG_W-1:0] rdData,
  output logic             clkRunning,
  output dpCtrl_t          ctl
);
  localparam logic [REG_W-1:0] WR_MASK = writeMask();
  localparam logic [SRC_W-1:0] SRC_CAP = SRC_W'(MAX_SRC_CODE);

  logic [REG_W-1:0] cfgReg;
  logic [SRC_W-1:0] srcRaw, srcNext, srcAct;
  logic [FIN_W-1:0] finRaw;
  logic             finNext, finLongAct;

  always_ff @(posedge clk) begin
    if (!rstN)     cfgReg <= RESET_WORD;
    else if (wrEn) cfgReg <= wrData & WR_MASK;
  end

  always_comb begin
    srcRaw  = cfgReg[SRC_LSB +: SRC_W];
    finRaw  = cfgReg[FIN_LSB +: FIN_W];
    srcNext = (srcRaw > SRC_CAP) ? SRC_CAP : srcRaw;
    finNext = (finRaw != '0);
  end

  // Divider selects are only swapped at the card-period boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAct     <= RESET_WORD[SRC_LSB +: SRC_W];
      finLongAct <= (RESET_WORD[FIN_LSB +: FIN_W] != '0);
    end else if (cardTick) begin
      srcAct     <= srcNext;
      finLongAct <= finNext;
    end
  end

  always_comb begin
    ctl.srcCode  = srcAct;
    ctl.finLong  = finLongAct;
    ctl.holdCard = cfgReg[CARD_STOP_POS];
    ctl.holdHost = cfgReg[HOST_STOP_POS] | (srcAct >= SRC_W'(HOST_OFF_CODE));
  end

  assign rdData     = cfgReg;
  assign clkRunning = ~cfgReg[HOST_STOP_POS] & ~cfgReg[CARD_STOP_POS];

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cardTick |=> $stable({srcAct, finLongAct}));
  // R5
  src_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcAct <= SRC_CAP);
endmodule

// File: rtl/cardclk_dp.sv
module cardclk_dp
  import cardclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctl,
  output logic    cardTick,
  output logic    hostClkEn,
  output logic    cardClkEn
);
  logic [PRE_W-1:0] preCnt, preLast;
  logic [PRE_W:0]   preSpan;
  logic [1:0]       postCnt, postLast;
  logic             hostTick;

  always_comb begin
    preSpan  = ({{PRE_W{1'b0}}, 1'b1} << ctl.srcCode) - 1'b1;
    preLast  = preSpan[PRE_W-1:0];
    postLast = ctl.finLong ? 2'd3 : 2'd1;
    hostTick = (preCnt == preLast);
    cardTick = hostTick && (postCnt == postLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else begin
      preCnt <= hostTick ? '0 : preCnt + 1'b1;
      if (cardTick)      postCnt <= '0;
      else if (hostTick) postCnt <= postCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostClkEn <= 1'b0;
      cardClkEn <= 1'b0;
    end else begin
      hostClkEn <= hostTick & ~ctl.holdHost;
      cardClkEn <= cardTick & ~ctl.holdCard;
    end
  end

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLast);
  // R4
  card_on_host_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardClkEn && !$past(ctl.holdHost)) |-> hostClkEn);
  // R4
  card_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardClkEn |=> !cardClkEn);
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div
  import cardclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             hostClkEn,
  output logic             cardClkEn,
  output logic             clkRunning
);
  dpCtrl_t ctl;
  logic    cardTick;

  cardclk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cardTick(cardTick), .rdData(rdData), .clkRunning(clkRunning), .ctl(ctl)
  );

  cardclk_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cardTick(cardTick),
    .hostClkEn(hostClkEn), .cardClkEn(cardClkEn)
  );
endmodule

// File: tb/cardclk_div_tb_top.sv
module cardclk_div_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [9:0] wrData = '0;
  logic [9:0] rdData;
  logic       hostClkEn, cardClkEn, clkRunning;

  int testsRun = 0;
  int testsFailed = 0;
  int cycle = 0;

  typedef struct { int cardPer; int hostPer; } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cycle++;

  cardclk_div dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .hostClkEn(hostClkEn), .cardClkEn(cardClkEn), .clkRunning(clkRunning)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [9:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: program a ratio, let the boundary pass, then push the expectation
  task automatic driveCfg(input logic [9:0] d, input int cardPer, input int hostPer);
    writeReg(d);
    idle(140);
    expQ.push_back('{cardPer, hostPer});
    wait (expQ.size() == 0);
  endtask

  // Monitor: pops an expectation and measures the enable periods
  initial begin
    forever begin
      expItem_t it;
      int n;
      wait (expQ.size() > 0);
      it = expQ[0];
      do @(negedge clk); while (!cardClkEn);
      n = 0;
      do begin @(negedge clk); n++; end while (!cardClkEn && n < 200);
      check(n == it.cardPer, "R4,R3,R5 card period", n, it.cardPer);
      if (it.hostPer > 0) begin
        do @(negedge clk); while (!hostClkEn);
        n = 0;
        do begin @(negedge clk); n++; end while (!hostClkEn && n < 200);
        check(n == it.hostPer, "R3 host period", n, it.hostPer);
      end else begin
        n = 0;
        for (int k = 0; k < 2 * it.cardPer; k++) begin
          @(negedge clk); if (hostClkEn) n++;
        end
        check(n == 0, "R8,R7 host held low", n, 0);
      end
      void'(expQ.pop_front());
    end
  end

  initial begin
    #(8 * 150000);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int t0, t1, t2, hc, cc;
    idle(4);
    rstN = 1'b1;
    idle(20);
    // R1
    check(rdData == 10'h301, "R1 reset word", rdData, 10'h301);
    check(!hostClkEn && !cardClkEn, "R1 outputs low", {hostClkEn, cardClkEn}, 0);
    check(!clkRunning, "R1 running low", clkRunning, 0);

    // R2
    writeReg(10'h3FF);
    check(rdData == 10'h31F, "R2 readback", rdData, 10'h31F);

    // R3 R4: all ten legal combinations; host stop set for source code >= 2
    for (int fin = 0; fin < 2; fin++) begin
      for (int src = 0; src < 5; src++) begin
        logic [9:0] w;
        int pre;
        pre = 1 << src;
        w = 10'((src >= 2 ? 10'h200 : 10'h000) | (src << 2) | fin);
        driveCfg(w, pre * (fin ? 4 : 2), (src >= 2) ? 0 : pre);
      end
    end

    // R10: change fields mid-period of the divide-by-64 setting
    do @(negedge clk); while (!cardClkEn);
    t0 = cycle;
    idle(5);
    writeReg(10'h000);
    do @(negedge clk); while (!cardClkEn);
    t1 = cycle;
    check(t1 - t0 == 64, "R10 old period completes", t1 - t0, 64);
    do @(negedge clk); while (!cardClkEn);
    t2 = cycle;
    check(t2 - t1 == 2, "R10 new period after boundary", t2 - t1, 2);
    check(clkRunning, "R9 running with both stops clear", clkRunning, 1);

    // R5: reserved codes clamp
    driveCfg(10'h21F, 64, 0);
    driveCfg(10'h214, 32, 0);
    driveCfg(10'h002, 4, 1);

    // R8: host bit clear but source code 2 still withholds host enable
    driveCfg(10'h008, 8, 0);

    // R6: card stop alone
    writeReg(10'h100);
    idle(140);
    hc = 0; cc = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (hostClkEn) hc++;
      if (cardClkEn) cc++;
    end
    check(cc == 0, "R6 card gated", cc, 0);
    check(hc == 40, "R6 host keeps running", hc, 40);
    check(!clkRunning, "R9 running low with card stop", clkRunning, 0);

    // R7: host stop alone
    writeReg(10'h200);
    idle(20);
    hc = 0; cc = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (hostClkEn) hc++;
      if (cardClkEn) cc++;
    end
    check(hc == 0, "R7 host gated", hc, 0);
    check(cc == 20, "R7 card keeps running", cc, 20);
    check(!clkRunning, "R9 running low with host stop", clkRunning, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule